// File: doc/BRIEF.md
# I2C Bulk Transfer Command Sequencer

This block sits between a host byte channel and a byte-level I2C master engine. It takes bulk transfer commands from the host, one byte at a time. Each command carries a 16-bit length. The block checks that length against a fixed buffer capacity and then carries out the transfer as a series of engine requests (start, stop, write byte, read byte). Data moves both ways between the host and the engine, and the block answers the host with status bytes.

There are three commands: a bulk write, a bulk read, and a combined transfer that writes one byte and then reads N bytes. Two low bits in each command byte set the bus framing and the acknowledge policy. With them the host can build a transaction from several commands, or do the whole transaction in one command. When a request is too long, the block refuses it before any bus activity. The refusal reports the largest length the block accepts, so the host can split the transfer into smaller pieces.

Top module: `i2c_bulk_seq`

## Requirements
- R1: Command bytes of the form 001000xy (write), 001001xy (read) and 001010xy (write-one-then-read) start a transfer. Any other byte received while idle is taken from the host and dropped: no reply, no engine request. After reset the block is idle with rx_ready high, tx_valid low and eng_req low.
- R2: A command is followed by a big-endian 16-bit length N. When N exceeds MAX_LEN (default 128), the block replies with three bytes: 0x0E, then MAX_LEN high byte, then MAX_LEN low byte. It issues no engine request, takes no further host bytes for that command, and returns to idle.
- R3: When N is at most MAX_LEN, the block replies 0x01 before it issues any engine request.
- R4: For a write, the block issues START first when x=1. It then writes the N host bytes in order, issues STOP when y=1, and finally sends one status byte.
- R5: The write status is 0x01 unless the slave NACKs a byte other than the last one, in which case it is 0x0F. After such a NACK, the remaining host bytes are still consumed but not written. A NACK on the last byte alone leaves the status at 0x01.
- R6: A read never issues START. It issues N byte reads, forwards each byte to the host in bus order, and issues STOP when y=1. No status byte follows the data.
- R7: Every byte read except the last is acknowledged (eng_ack_out=1). The last byte is acknowledged only when x=1.
- R8: A write-one-then-read always issues START and writes exactly one host byte. It then sends 0x01 if the slave acknowledged that byte, or 0x0F if it did not. On 0x01, N reads follow under R6 and R7. On 0x0F, no read is issued. In both cases STOP is issued when y=1.
- R9: A length of zero is accepted. It results only in the optional START and STOP, plus the status byte that the command would normally send.
- R10: The engine opcode on eng_op is 0 for START, 1 for STOP, 2 for write, 3 for read. eng_req stays high with stable eng_op and eng_wdata until eng_done. tx_valid stays high with stable tx_data until tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block takes the host byte this cycle |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host takes the reply byte |
| eng_req | output | 1 | Engine request, held until done |
| eng_op | output | 2 | Engine opcode: 0 start, 1 stop, 2 write, 3 read |
| eng_wdata | output | 8 | Byte to write |
| eng_ack_out | output | 1 | For a read: 1 = master ACKs the byte |
| eng_done | input | 1 | Engine completes the request (one cycle) |
| eng_rdata | input | 8 | Byte read, valid with eng_done |
| eng_nack | input | 1 | Slave NACKed the written byte, valid with eng_done |

## Verification
The hardest case to reach is a slave NACK in the middle of a write while the host keeps sending data. The block must go on consuming the remaining bytes without writing them, and it must tell that NACK apart from a NACK on the final byte. A bench engine model takes a per-transaction NACK mask that sets which write operations are refused. Directed transfers place the NACK in the middle, on the last byte, and on the single byte of a write-one-then-read. Random transfers with sparse masks, random engine latency and random host back-pressure cover the remaining mixes of commands and lengths, including lengths right at and just over the capacity.

// File: rtl/i2c_bulk_pkg.sv
package i2c_bulk_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2,
        XF_WR1RD = 2'd3
    } xfer_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LHI, S_LLO, S_TX, S_REFH, S_REFL,
        S_START, S_BODY, S_WGET, S_WOP, S_ROP, S_STOP, S_FIN
    } state_e;

    localparam logic [7:0] RSP_OK     = 8'h01;
    localparam logic [7:0] RSP_TOOBIG = 8'h0E;
    localparam logic [7:0] RSP_NACK   = 8'h0F;

    localparam int LEN_W = 16;

    typedef struct packed {
        state_e             st;
        state_e             ret;
        xfer_e              kind;
        logic               x;
        logic               y;
        logic [7:0]         lhi;
        logic [LEN_W-1:0]   cnt;
        logic [7:0]         tbyte;
        logic [7:0]         wbuf;
        logic               err;
    } seq_t;

endpackage

// File: rtl/i2c_bulk_decode.sv
module i2c_bulk_decode
    import i2c_bulk_pkg::*;
(
    input  logic [7:0] cmd,
    output xfer_e      kind,
    output logic       flag_x,
    output logic       flag_y
);
    always_comb begin
        case (cmd[7:2])
            6'b001000: kind = XF_WRITE;
            6'b001001: kind = XF_READ;
            6'b001010: kind = XF_WR1RD;
            default:   kind = XF_NONE;
        endcase
        flag_x = cmd[1];
        flag_y = cmd[0];
    end
endmodule

// File: rtl/i2c_bulk_limit.sv
module i2c_bulk_limit
    import i2c_bulk_pkg::*;
#(
    parameter int MAX_LEN = 128
) (
    input  logic [LEN_W-1:0] len,
    output logic             too_big,
    output logic [7:0]       max_hi,
    output logic [7:0]       max_lo
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    assign too_big = (len > CAP);
    assign max_hi  = CAP[15:8];
    assign max_lo  = CAP[7:0];
endmodule

// File: rtl/i2c_bulk_seq.sv
module i2c_bulk_seq
    import i2c_bulk_pkg::*;
#(
    parameter int MAX_LEN = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       eng_req,
    output logic [1:0] eng_op,
    output logic [7:0] eng_wdata,
    output logic       eng_ack_out,
    input  logic       eng_done,
    input  logic [7:0] eng_rdata,
    input  logic       eng_nack
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    localparam seq_t SEQ_RST = '{
        st: S_IDLE, ret: S_IDLE, kind: XF_NONE, x: 1'b0, y: 1'b0,
        lhi: 8'h00, cnt: '0, tbyte: 8'h00, wbuf: 8'h00, err: 1'b0
    };

    seq_t q, d;

    xfer_e            dec_kind;
    logic             dec_x, dec_y;
    logic             len_big;
    logic [7:0]       cap_hi, cap_lo;
    logic             last;
    logic             need_start;
    eng_op_e          op_d;

    i2c_bulk_decode u_dec (
        .cmd    (rx_data),
        .kind   (dec_kind),
        .flag_x (dec_x),
        .flag_y (dec_y)
    );

    i2c_bulk_limit #(.MAX_LEN(MAX_LEN)) u_lim (
        .len     ({q.lhi, rx_data}),
        .too_big (len_big),
        .max_hi  (cap_hi),
        .max_lo  (cap_lo)
    );

    assign last       = (q.cnt == LEN_W'(1));
    assign need_start = (q.kind == XF_WR1RD) || ((q.kind == XF_WRITE) && q.x);

    always_comb begin
        d           = q;
        rx_ready    = 1'b0;
        tx_valid    = 1'b0;
        eng_req     = 1'b0;
        op_d        = ENG_START;
        eng_ack_out = 1'b1;
        case (q.st)
            S_IDLE: begin
                rx_ready = 1'b1;
                if (rx_valid && dec_kind != XF_NONE) begin
                    d.kind = dec_kind;
                    d.x    = dec_x;
                    d.y    = dec_y;
                    d.st   = S_LHI;
                end
            end
            S_LHI: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.lhi = rx_data;
                    d.st  = S_LLO;
                end
            end
            S_LLO: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.err = 1'b0;
                    d.st  = S_TX;
                    if (len_big) begin
                        d.tbyte = RSP_TOOBIG;
                        d.ret   = S_REFH;
                    end else begin
                        d.tbyte = RSP_OK;
                        d.cnt   = {q.lhi, rx_data};
                        d.ret   = S_START;
                    end
                end
            end
            S_TX: begin
                tx_valid = 1'b1;
                if (tx_ready) d.st = q.ret;
            end
            S_REFH: begin
                d.tbyte = cap_hi;
                d.ret   = S_REFL;
                d.st    = S_TX;
            end
            S_REFL: begin
                d.tbyte = cap_lo;
                d.ret   = S_IDLE;
                d.st    = S_TX;
            end
            S_START: begin
                if (!need_start) begin
                    d.st = S_BODY;
                end else begin
                    eng_req = 1'b1;
                    op_d    = ENG_START;
                    if (eng_done) d.st = (q.kind == XF_WR1RD) ? S_WGET : S_BODY;
                end
            end
            S_BODY: begin
                if (q.cnt == '0)            d.st = S_STOP;
                else if (q.kind == XF_WRITE) d.st = S_WGET;
                else                         d.st = S_ROP;
            end
            S_WGET: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.wbuf = rx_data;
                    if (q.kind == XF_WRITE && q.err) begin
                        d.cnt = q.cnt - LEN_W'(1);
                        d.st  = S_BODY;
                    end else begin
                        d.st = S_WOP;
                    end
                end
            end
            S_WOP: begin
                eng_req = 1'b1;
                op_d    = ENG_WRITE;
                if (eng_done) begin
                    if (q.kind == XF_WR1RD) begin
                        d.tbyte = eng_nack ? RSP_NACK : RSP_OK;
                        d.ret   = eng_nack ? S_STOP : S_BODY;
                        d.st    = S_TX;
                    end else begin
                        if (eng_nack && !last) d.err = 1'b1;
                        d.cnt = q.cnt - LEN_W'(1);
                        d.st  = S_BODY;
                    end
                end
            end
            S_ROP: begin
                eng_req     = 1'b1;
                op_d        = ENG_READ;
                eng_ack_out = !last || q.x;
                if (eng_done) begin
                    d.tbyte = eng_rdata;
                    d.cnt   = q.cnt - LEN_W'(1);
                    d.ret   = S_BODY;
                    d.st    = S_TX;
                end
            end
            S_STOP: begin
                if (!q.y) begin
                    d.st = S_FIN;
                end else begin
                    eng_req = 1'b1;
                    op_d    = ENG_STOP;
                    if (eng_done) d.st = S_FIN;
                end
            end
            S_FIN: begin
                if (q.kind == XF_WRITE) begin
                    d.tbyte = q.err ? RSP_NACK : RSP_OK;
                    d.ret   = S_IDLE;
                    d.st    = S_TX;
                end else begin
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    assign tx_data   = q.tbyte;
    assign eng_op    = op_d;
    assign eng_wdata = q.wbuf;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    // R10: engine request and its payload hold until completion
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wdata));

    // R10: reply byte holds until taken
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R6: a read command never asks for START
    a_r6_no_read_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_op == ENG_START |-> q.kind != XF_READ);

    // R2: an accepted transfer never counts beyond capacity
    a_r2_cnt_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CAP);

    // R3: no engine activity while a reply byte is pending
    a_r3_reply_first: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && eng_req));

endmodule

// File: tb/tb_i2c_bulk_seq.sv
module tb_i2c_bulk_seq;
    localparam int MAXL = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       eng_req;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic       eng_ack_out;
    logic       eng_done = 1'b0;
    logic [7:0] eng_rdata = 8'h00;
    logic       eng_nack = 1'b0;

    i2c_bulk_seq #(.MAX_LEN(MAXL)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_ack_out(eng_ack_out), .eng_done(eng_done),
        .eng_rdata(eng_rdata), .eng_nack(eng_nack)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int hs_viol = 0;
    logic [7:0] host_q[$];
    logic [7:0] got_tx[$];
    logic [7:0] exp_tx[$];
    int got_ops[$];
    int exp_ops[$];
    logic [255:0] nack_mask = '0;
    int rd_cnt = 0;
    int wr_idx = 0;
    int dly = 0;
    logic running = 1'b0;

    function automatic logic [7:0] rd_val(int i);
        return 8'((i * 37 + 90) & 255);
    endfunction

    function automatic int op_code(int op, int ack, int data);
        return op * 1024 + ((op == 3) ? ack * 256 : 0) + ((op == 2) ? data : 0);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // host byte feeder
    initial begin
        forever begin
            @(negedge clk);
            rx_valid = running && (host_q.size() > 0);
            rx_data  = (host_q.size() > 0) ? host_q[0] : 8'h00;
            #1;
            if (rx_valid && rx_ready) begin
                @(posedge clk);
                void'(host_q.pop_front());
            end
        end
    end

    // host reply sink with random back-pressure
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            #1;
            if (tx_valid && tx_ready) got_tx.push_back(tx_data);
        end
    end

    // byte-level engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_done) begin
                eng_done = 1'b0;
                eng_nack = 1'b0;
                dly = $urandom % 4;
            end else if (eng_req) begin
                if (dly == 0) begin
                    eng_done = 1'b1;
                    got_ops.push_back(op_code(int'(eng_op), int'(eng_ack_out), int'(eng_wdata)));
                    if (eng_op == 2'd3) begin
                        eng_rdata = rd_val(rd_cnt);
                        rd_cnt++;
                    end
                    if (eng_op == 2'd2) begin
                        eng_nack = nack_mask[wr_idx[7:0]];
                        wr_idx++;
                    end
                end else begin
                    dly--;
                end
            end
        end
    end

    // handshake hold monitor (R10)
    initial begin
        logic pv, pr, er, ed;
        logic [7:0] pd, pw;
        logic [1:0] po;
        pv = 0; pr = 0; er = 0; ed = 0; pd = 0; pw = 0; po = 0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (pv && !pr && (!tx_valid || tx_data != pd)) hs_viol++;
                if (er && !ed && (!eng_req || eng_op != po || eng_wdata != pw)) hs_viol++;
            end
            pv = tx_valid; pr = tx_ready; pd = tx_data;
            er = eng_req; ed = eng_done; po = eng_op; pw = eng_wdata;
        end
    end

    task automatic run(string tag, logic [7:0] cmd, int len, logic [255:0] nm);
        logic [7:0] dat[$];
        bit valid, refuse, err, nk;
        int kind, wi, nd, waited;
        kind = int'(cmd[7:2]);
        valid = (kind == 8) || (kind == 9) || (kind == 10);
        refuse = valid && (len > MAXL);
        got_tx.delete(); got_ops.delete(); exp_tx.delete(); exp_ops.delete();
        nack_mask = nm; rd_cnt = 0; wr_idx = 0;
        nd = 0;
        if (valid && !refuse) nd = (kind == 8) ? len : ((kind == 10) ? 1 : 0);
        for (int i = 0; i < nd; i++) dat.push_back(8'($urandom));
        if (valid) begin
            if (refuse) begin
                exp_tx.push_back(8'h0E);
                exp_tx.push_back(8'(MAXL >> 8));
                exp_tx.push_back(8'(MAXL & 255));
            end else begin
                exp_tx.push_back(8'h01);
                if (kind == 8) begin
                    if (cmd[1]) exp_ops.push_back(op_code(0, 0, 0));
                    err = 0; wi = 0;
                    for (int i = 0; i < len; i++) begin
                        if (!err) begin
                            exp_ops.push_back(op_code(2, 0, int'(dat[i])));
                            if (nm[wi] && i != len - 1) err = 1;
                            wi++;
                        end
                    end
                    if (cmd[0]) exp_ops.push_back(op_code(1, 0, 0));
                    exp_tx.push_back(err ? 8'h0F : 8'h01);
                end else begin
                    nk = 0;
                    if (kind == 10) begin
                        exp_ops.push_back(op_code(0, 0, 0));
                        exp_ops.push_back(op_code(2, 0, int'(dat[0])));
                        nk = nm[0];
                        exp_tx.push_back(nk ? 8'h0F : 8'h01);
                    end
                    if (!nk) begin
                        for (int i = 0; i < len; i++) begin
                            exp_ops.push_back(op_code(3, ((i != len - 1) || cmd[1]) ? 1 : 0, 0));
                            exp_tx.push_back(rd_val(i));
                        end
                    end
                    if (cmd[0]) exp_ops.push_back(op_code(1, 0, 0));
                end
            end
        end
        host_q.push_back(cmd);
        if (valid) begin
            host_q.push_back(8'(len >> 8));
            host_q.push_back(8'(len & 255));
        end
        foreach (dat[i]) host_q.push_back(dat[i]);
        waited = 0;
        while ((host_q.size() > 0 || got_tx.size() < exp_tx.size()) && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        check(host_q.size() == 0, tag, "host bytes left", host_q.size(), 0);
        check(got_tx.size() == exp_tx.size(), tag, "reply count", got_tx.size(), exp_tx.size());
        if (got_tx.size() == exp_tx.size())
            foreach (exp_tx[i])
                if (got_tx[i] != exp_tx[i]) begin
                    check(0, tag, $sformatf("reply byte %0d", i), int'(got_tx[i]), int'(exp_tx[i]));
                    break;
                end
        check(got_ops.size() == exp_ops.size(), tag, "engine op count", got_ops.size(), exp_ops.size());
        if (got_ops.size() == exp_ops.size())
            foreach (exp_ops[i])
                if (got_ops[i] != exp_ops[i]) begin
                    check(0, tag, $sformatf("engine op %0d", i), got_ops[i], exp_ops[i]);
                    break;
                end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] nm;
        int r;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(rx_ready == 1'b1 && tx_valid == 1'b0 && eng_req == 1'b0, "R1",
              "reset idle outputs", {rx_ready, tx_valid, eng_req}, 3'b100);
        running = 1'b1;

        // directed corners
        run("R1", 8'h2C, 0, '0);                     // 001011xx: not a command
        run("R1", 8'h00, 0, '0);
        run("R4", 8'h23, 5, '0);                     // START + 5 writes + STOP
        run("R5", 8'h23, 6, 256'b100);               // NACK on third byte
        run("R5", 8'h23, 4, 256'b1000);              // NACK on final byte only
        run("R6", 8'h25, 4, '0);                     // read, last NACKed, STOP
        run("R7", 8'h27, 3, '0);                     // read, last ACKed
        run("R8", 8'h29, 4, '0);                     // write one then read
        run("R8", 8'h29, 4, 256'b1);                 // NACK on the written byte
        run("R9", 8'h23, 0, '0);
        run("R9", 8'h24, 0, '0);
        run("R9", 8'h2A, 0, '0);
        run("R3", 8'h20, MAXL, '0);                  // exactly at capacity
        run("R2", 8'h20, MAXL + 1, '0);              // one over capacity
        run("R2", 8'h25, 16'hFFFF, '0);

        // random mix
        for (int t = 0; t < 60; t++) begin
            logic [7:0] c;
            int len;
            r = $urandom % 10;
            c = (r < 4) ? 8'h20 : (r < 7) ? 8'h24 : (r < 9) ? 8'h28 : 8'h30;
            c[1:0] = 2'($urandom);
            r = $urandom % 8;
            len = (r == 0) ? MAXL - 1 + ($urandom % 3) : ($urandom % 20);
            nm = '0;
            for (int b = 0; b < 256; b++) nm[b] = (($urandom % 10) == 0);
            run((c[7:2] == 6'b001000) ? "R5" : (c[7:2] == 6'b001001) ? "R7" :
                (c[7:2] == 6'b001010) ? "R8" : "R1", c, len, nm);
        end

        check(hs_viol == 0, "R10", "handshake hold violations", hs_viol, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule